// File: doc/BRIEF.md
# Fast Interrupt Fetch Sequencer

This block sits in front of an instruction-fetch stage. In normal operation it presents a sequential fetch address that moves forward each time the fetch stage accepts a word. When an interrupt is pending and the spacing rule allows it, the block splices the two words stored at the interrupt's vector address into the fetch stream and marks them as injected. After the second injected word has been accepted, normal fetching resumes on its own at the address that was due before the splice. No return instruction is needed, and no processor state is saved.

The decode stage reports back through hint inputs. These say whether the decoded instruction came from an injected slot, and whether it is a subroutine jump, a return from interrupt, or an opcode that is not allowed in the slot. A subroutine jump decoded from the slot turns the service into a long interrupt. The block pushes the interrupted program address and the current status word onto a small internal stack and redirects fetch to the jump target. It holds off new injections until a return-from-interrupt decode pops the stack and restores both values.

A pacing counter counts decoded normal-stream instructions, not cycles. It keeps interrupt decodes spread out: at least four normal instructions must sit between two of them. A request that arrives too early stays latched until it is allowed.

Top module: `fast_irq_seq`

## Requirements
- R1: While reset is asserted and after it is released, fetch_addr equals RST_VEC (default 16'h0100), fetch_inj is 0, sr_load is 0, both error flags are 0, no request is pending and the pacing count is zero.
- R2: Outside a slot, each clock edge with fetch_rdy high advances fetch_addr by 1. With fetch_rdy low and no redirecting decode, fetch_addr holds.
- R3: Once a service starts, the next two accepted fetches are at vector and vector+1 with fetch_inj high. The following fetch is at the normal-stream address that was due when the service began. The slot never changes that address, and sr_load stays 0.
- R4: An irq_req pulse is latched together with irq_vec and is serviced later if it cannot start at once. While a request is pending, further requests are ignored, and the first vector is the one serviced.
- R5: A service starts only after at least GAP (default 4) normal decodes (dec_valid high, dec_inj low). These are counted since the later of reset, the last service start, and the last injected decode. Cycles without decodes do not count.
- R6: An injected decode with dec_jsr high, when the stack is not full, pushes the pending return address and sr_in. On the next cycle fetch_addr equals dec_target with fetch_inj low.
- R7: While the stack holds any entry, no service starts. A request raised meanwhile stays pending and starts once the stack has emptied.
- R8: A decode with dec_rti high and a non-empty stack pops the top entry. On the next cycle fetch_addr equals the saved return address, sr_out equals the saved status, and sr_load is high for exactly that one cycle.
- R9: An injected decode with dec_illegal high sets err_illegal, which then stays set until reset. A normal decode with dec_illegal high leaves err_illegal at 0.
- R10: A return decode on an empty stack, or an injected jump decode on a full stack, sets err_stack, which then stays set until reset. Neither case moves fetch_addr or pulses sr_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request pulse |
| irq_vec | input | AW | Vector address sampled with irq_req |
| fetch_rdy | input | 1 | Fetch stage accepts fetch_addr at this edge |
| fetch_addr | output | AW | Address of the word to fetch |
| fetch_inj | output | 1 | Current fetch is an injected slot word |
| dec_valid | input | 1 | One instruction decoded this cycle |
| dec_inj | input | 1 | Decoded instruction came from an injected slot |
| dec_jsr | input | 1 | Decoded instruction is a subroutine jump |
| dec_rti | input | 1 | Decoded instruction is a return from interrupt |
| dec_illegal | input | 1 | Decoded opcode is forbidden in the slot |
| dec_target | input | AW | Jump target of the decoded instruction |
| sr_in | input | SW | Current status word, saved on a push |
| sr_out | output | SW | Status word restored by a pop |
| sr_load | output | 1 | One-cycle strobe: load sr_out into status |
| err_illegal | output | 1 | Sticky: forbidden opcode decoded in a slot |
| err_stack | output | 1 | Sticky: stack overflow or underflow |

## Verification
The properties assume that the decode stage reports at most one instruction per cycle. They also assume that dec_inj is raised only for words that really came out of a slot. The hold property further assumes that the address moves only through fetch_rdy, through a service start, or through a decode that redirects. The stimulus drives every input from a single driver on the falling clock edge and keeps decode hints to one-cycle pulses. It issues injected hints only after the matching slot words have been fetched. It holds fetch_rdy low whenever a service starts or a redirect lands, so that the expected addresses follow from the requirements alone.

// File: rtl/fifs_pkg.sv
package fifs_pkg;
    // Fetch sequencing modes: normal stream, first slot word, second slot word.
    typedef enum logic [1:0] {
        FM_RUN   = 2'd0,
        FM_SLOT0 = 2'd1,
        FM_SLOT1 = 2'd2
    } fmode_e;
endpackage

// File: rtl/fifs_pend.sv
// Single-entry request latch: holds one vector until the sequencer takes it.
module fifs_pend #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_vec,
    input  logic          take,
    output logic          pend,
    output logic [AW-1:0] pend_vec
);
    typedef struct packed {
        logic          v;
        logic [AW-1:0] a;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.v = 1'b0;
        if (req && (!st_q.v || take)) begin
            st_d.v = 1'b1;
            st_d.a = req_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend     = st_q.v;
    assign pend_vec = st_q.a;
endmodule

// File: rtl/fifs_gap.sv
// Saturating count of normal-stream decodes since the last interrupt event.
module fifs_gap #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic norm,
    input  logic clr,
    output logic ok
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] LIM = CW'(GAP);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_t;

    gap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)                       st_d.cnt = '0;
        else if (norm && st_q.cnt < LIM) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok = (st_q.cnt >= LIM);
endmodule

// File: rtl/fifs_stack.sv
// Small LIFO for return address and status word.
module fifs_stack #(
    parameter int EW    = 24,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] din,
    output logic [EW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] TOP = PW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            sp;
    } stk_t;

    stk_t st_d, st_q;
    logic [IW-1:0] rd_idx;

    assign empty  = (st_q.sp == '0);
    assign full   = (st_q.sp == TOP);
    assign rd_idx = empty ? '0 : IW'(st_q.sp - 1'b1);
    assign dout   = st_q.mem[rd_idx];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.mem[IW'(st_q.sp)] = din;
            st_d.sp = st_q.sp + 1'b1;
        end else if (pop && !empty) begin
            st_d.sp = st_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fast_irq_seq.sv
module fast_irq_seq
    import fifs_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          SW      = 8,
    parameter int          DEPTH   = 4,
    parameter int          GAP     = 4,
    parameter logic [15:0] RST_VEC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic [AW-1:0] irq_vec,
    input  logic          fetch_rdy,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_inj,
    input  logic          dec_valid,
    input  logic          dec_inj,
    input  logic          dec_jsr,
    input  logic          dec_rti,
    input  logic          dec_illegal,
    input  logic [AW-1:0] dec_target,
    input  logic [SW-1:0] sr_in,
    output logic [SW-1:0] sr_out,
    output logic          sr_load,
    output logic          err_illegal,
    output logic          err_stack
);
    localparam int EW = AW + SW;

    typedef struct packed {
        fmode_e        mode;
        logic [AW-1:0] pc;
        logic [AW-1:0] vec;
        logic [AW-1:0] ret;
        logic [SW-1:0] sr_out;
        logic          sr_load;
        logic          err_ill;
        logic          err_stk;
    } seq_t;

    seq_t st_d, st_q;

    logic          pend, gap_ok, stk_empty, stk_full;
    logic [AW-1:0] pend_vec;
    logic [EW-1:0] stk_dout;
    logic          jsr_hit, rti_hit, do_push, do_pop, take;

    assign jsr_hit = dec_valid && dec_inj && dec_jsr;
    assign rti_hit = dec_valid && dec_rti;
    assign do_push = jsr_hit && !stk_full;
    assign do_pop  = rti_hit && !stk_empty;
    assign take    = (st_q.mode == FM_RUN) && pend && gap_ok && stk_empty
                     && !jsr_hit && !rti_hit;

    fifs_pend #(.AW(AW)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .req_vec(irq_vec),
        .take(take), .pend(pend), .pend_vec(pend_vec)
    );

    fifs_gap #(.GAP(GAP)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .norm(dec_valid && !dec_inj),
        .clr(take || (dec_valid && dec_inj)),
        .ok(gap_ok)
    );

    fifs_stack #(.EW(EW), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
        .din({st_q.ret, sr_in}), .dout(stk_dout),
        .empty(stk_empty), .full(stk_full)
    );

    always_comb begin
        st_d = st_q;
        st_d.sr_load = 1'b0;
        unique case (st_q.mode)
            FM_RUN:   if (fetch_rdy) st_d.pc   = st_q.pc + 1'b1;
            FM_SLOT0: if (fetch_rdy) st_d.mode = FM_SLOT1;
            FM_SLOT1: if (fetch_rdy) st_d.mode = FM_RUN;
            default:  st_d.mode = FM_RUN;
        endcase
        if (take) begin
            st_d.mode = FM_SLOT0;
            st_d.vec  = pend_vec;
            st_d.ret  = st_d.pc;
        end
        if (do_push) begin
            st_d.pc   = dec_target;
            st_d.mode = FM_RUN;
        end
        if (do_pop) begin
            st_d.pc      = stk_dout[EW-1:SW];
            st_d.sr_out  = stk_dout[SW-1:0];
            st_d.sr_load = 1'b1;
            st_d.mode    = FM_RUN;
        end
        if ((jsr_hit && stk_full) || (rti_hit && stk_empty)) st_d.err_stk = 1'b1;
        if (dec_valid && dec_inj && dec_illegal)              st_d.err_ill = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= FM_RUN;
            st_q.pc   <= AW'(RST_VEC);
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_inj   = (st_q.mode != FM_RUN);
    assign fetch_addr  = (st_q.mode == FM_RUN) ? st_q.pc
                       : st_q.vec + AW'(st_q.mode == FM_SLOT1);
    assign sr_out      = st_q.sr_out;
    assign sr_load     = st_q.sr_load;
    assign err_illegal = st_q.err_ill;
    assign err_stack   = st_q.err_stk;
endmodule

// File: rtl/fifs_chk.sv
module fifs_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_rdy,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_inj,
    input logic          dec_valid,
    input logic          dec_rti,
    input logic          sr_load,
    input logic          err_illegal,
    input logic          err_stack,
    input logic          gap_ok,
    input logic          stk_empty
);
    // R2: stalled fetch with no redirect keeps its address unless a slot opens
    a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_rdy && !dec_valid && !fetch_inj) |=> (fetch_inj || $stable(fetch_addr)));

    // R3: after two accepted slot words the stream is back to normal
    a_r3_two_words: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_inj && fetch_rdy && $past(fetch_inj && fetch_rdy) && !dec_valid) |=> !fetch_inj);

    // R3/R8: status restore only follows a return decode
    a_r8_sr_after_rti: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> $past(dec_valid && dec_rti));

    // R5: a slot opens only when the pacing count was met
    a_r5_paced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_inj) |-> $past(gap_ok));

    // R7: no injection while a long service is on the stack
    a_r7_no_inj_long: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_inj |-> stk_empty);

    // R9: illegal-slot flag is sticky
    a_r9_ill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |=> err_illegal);

    // R10: stack error flag is sticky
    a_r10_stk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_stack |=> err_stack);
endmodule

bind fast_irq_seq fifs_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_rdy(fetch_rdy), .fetch_addr(fetch_addr),
    .fetch_inj(fetch_inj), .dec_valid(dec_valid), .dec_rti(dec_rti),
    .sr_load(sr_load), .err_illegal(err_illegal), .err_stack(err_stack),
    .gap_ok(gap_ok), .stk_empty(stk_empty)
);

// File: tb/sim_fast_irq_seq.sv
module sim_fast_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] irq_vec = '0;
    logic        fetch_rdy = 1'b0;
    logic [15:0] fetch_addr;
    logic        fetch_inj;
    logic        dec_valid = 1'b0, dec_inj = 1'b0, dec_jsr = 1'b0;
    logic        dec_rti = 1'b0, dec_illegal = 1'b0;
    logic [15:0] dec_target = '0;
    logic [7:0]  sr_in = '0;
    logic [7:0]  sr_out;
    logic        sr_load, err_illegal, err_stack;

    int checks = 0;
    int errors = 0;
    int srl_seen = 0;
    bit done = 1'b0;

    typedef struct { logic [15:0] a; logic i; } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    fast_irq_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .fetch_rdy(fetch_rdy), .fetch_addr(fetch_addr), .fetch_inj(fetch_inj),
        .dec_valid(dec_valid), .dec_inj(dec_inj), .dec_jsr(dec_jsr),
        .dec_rti(dec_rti), .dec_illegal(dec_illegal), .dec_target(dec_target),
        .sr_in(sr_in), .sr_out(sr_out), .sr_load(sr_load),
        .err_illegal(err_illegal), .err_stack(err_stack)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_exp(logic [15:0] a, logic i);
        exp_t e;
        e.a = a; e.i = i;
        expq.push_back(e);
    endtask

    // Monitor: scoreboard for every accepted fetch, plus sr_load strobe count
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && fetch_rdy) begin
                if (expq.size() == 0) begin
                    chk("R2/R3 unexpected fetch", {fetch_inj, fetch_addr}, 32'hFFFF);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk("R2/R3 fetch", {15'd0, fetch_inj, fetch_addr}, {15'd0, e.i, e.a});
                end
            end
            if (rst_n && sr_load) srl_seen++;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fetch_rdy = 1'b1;
        end
        @(negedge clk);
        fetch_rdy = 1'b0;
    endtask

    task automatic irq(logic [15:0] v);
        @(negedge clk);
        irq_req = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic dec(logic inj, logic jsr, logic rti, logic ill, logic [15:0] tgt);
        @(negedge clk);
        dec_valid = 1'b1; dec_inj = inj; dec_jsr = jsr;
        dec_rti = rti; dec_illegal = ill; dec_target = tgt;
        @(negedge clk);
        dec_valid = 1'b0; dec_inj = 1'b0; dec_jsr = 1'b0;
        dec_rti = 1'b0; dec_illegal = 1'b0;
    endtask

    task automatic norm_decs(int n);
        for (int k = 0; k < n; k++) dec(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic look(string req, logic [15:0] a, logic i);
        #2;
        chk(req, {15'd0, fetch_inj, fetch_addr}, {15'd0, i, a});
    endtask

    initial begin
        // Watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        #2;
        chk("R1 addr", fetch_addr, 16'h0100);
        chk("R1 flags", {fetch_inj, sr_load, err_illegal, err_stack}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        look("R1 after release", 16'h0100, 1'b0);

        // R2: sequential fetch, then hold with fetch_rdy low
        push_exp(16'h0100, 0); push_exp(16'h0101, 0); push_exp(16'h0102, 0);
        go(3);
        idle(3);
        look("R2 hold", 16'h0103, 1'b0);

        // R5: cycles without decodes do not satisfy pacing; R4: request held
        irq(16'h0040);
        idle(5);
        look("R5 idle cycles", 16'h0103, 1'b0);
        norm_decs(3);
        idle(1);
        look("R5 three decodes", 16'h0103, 1'b0);
        irq(16'h0080);                      // R4: ignored while one pending
        norm_decs(1);
        idle(2);
        look("R4 first vector serviced", 16'h0040, 1'b1);

        // R3: two slot words then resume at unchanged normal address
        push_exp(16'h0040, 1); push_exp(16'h0041, 1);
        push_exp(16'h0103, 0); push_exp(16'h0104, 0);
        go(4);
        idle(1);
        look("R3 resumed", 16'h0105, 1'b0);
        chk("R3 no sr_load", srl_seen, 0);
        dec(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        dec(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        chk("R3 no error", {err_illegal, err_stack}, 2'b00);

        // R5: spacing after a serviced interrupt
        irq(16'h0060);
        norm_decs(3);
        idle(2);
        look("R5 spacing after service", 16'h0105, 1'b0);
        norm_decs(1);
        idle(2);
        look("R5 spacing met", 16'h0060, 1'b1);

        // R6: slot jump turns into long service
        push_exp(16'h0060, 1);
        go(1);
        sr_in = 8'hA5;
        dec(1'b1, 1'b1, 1'b0, 1'b0, 16'h0200);
        sr_in = 8'h00;
        look("R6 redirect", 16'h0200, 1'b0);
        push_exp(16'h0200, 0); push_exp(16'h0201, 0);
        go(2);

        // R7: held off while long service is active
        irq(16'h0070);
        norm_decs(4);
        idle(3);
        look("R7 held off", 16'h0202, 1'b0);

        // R8: return pops address and status
        dec(1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        look("R8 restore addr", 16'h0105, 1'b0);
        chk("R8 sr_load", sr_load, 1'b1);
        chk("R8 sr_out", sr_out, 8'hA5);
        idle(1);
        chk("R8 sr_load one cycle", sr_load, 1'b0);
        look("R7 pending served after return", 16'h0070, 1'b1);
        push_exp(16'h0070, 1); push_exp(16'h0071, 1); push_exp(16'h0105, 0);
        go(3);

        // R9: illegal only counts in a slot
        dec(1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R9 normal illegal ignored", err_illegal, 1'b0);
        dec(1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
        chk("R9 slot illegal", err_illegal, 1'b1);
        idle(4);
        chk("R9 sticky", err_illegal, 1'b1);

        // R10: return on empty stack
        chk("R10 before", err_stack, 1'b0);
        dec(1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        chk("R10 underflow", err_stack, 1'b1);
        look("R10 addr unchanged", 16'h0106, 1'b0);
        chk("R10 no sr_load", sr_load, 1'b0);
        idle(3);
        chk("R10 sticky", err_stack, 1'b1);

        chk("R3 scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule